// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block accepts characters through a small write-side FIFO and shifts each one out on a single transmit line. Each frame is timed by an external oversample strobe, with sixteen strobes per bit. A frame opens with a low start bit. The data bits follow, least significant bit first, and the frame length is configurable. An optional parity bit comes next, then one or two high stop bits. Between frames the line rests high. While the FIFO holds characters and transmission is enabled, frames follow one another with no idle gap.

A finite state machine controls the frame. Its states are IDLE, START, DATA, PARITY and STOP. Its transitions are:

- IDLE→START when enabled and the FIFO is non-empty.
- START→DATA after one bit time.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after one bit time.
- STOP→STOP between the first and second of two stop bits.
- STOP→START when another character is ready and transmission is enabled.
- STOP→IDLE otherwise.

The frame settings are captured when a frame is loaded and stay fixed until that frame ends. A busy output covers both pending FIFO contents and the frame in flight. Busy stays high after the enable is dropped, until the last stop bit has been sent and the FIFO is empty.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, busy is low, the FIFO empty flag is high and the full flag is low.
- R2: Every frame begins with a low start bit.
- R3: The data bits are sent least significant bit first. Their count is 5 + `cfg_len`, so `cfg_len` 0 gives 5 bits and 3 gives 8 bits.
- R4: The stop bits are high. One is sent when `cfg_stop2` is 0 and two when it is 1.
- R5: When `cfg_par_en` is 1, a parity bit follows the data. It makes the count of ones over the sent data bits plus parity even when `cfg_par_odd` is 0, and odd when it is 1.
- R6: Length, parity and stop settings are sampled on the clock edge that loads a character. Changes after that edge do not affect the frame in flight.
- R7: A write is accepted only when the FIFO is not full, and a write while full is ignored. `fifo_full` and `fifo_empty` reflect the count one cycle after the edge. Characters go out in write order.
- R8: `busy` is high whenever the FIFO holds a character or a frame is in flight. It stays high after `tx_en` is removed until the final stop bit ends.
- R9: A frame is loaded only while `tx_en` is high. With `tx_en` high and data pending, the next start bit immediately follows the last stop bit.
- R10: Each bit lasts exactly 16 `tick` strobes. A bit changes on the clock after its 16th strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversample strobe, 16 per bit |
| tx_en | input | 1 | Allows new frames to start |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Character to queue |
| cfg_len | input | 2 | Data length select, bits = 5 + value |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| fifo_full | output | 1 | FIFO holds DEPTH characters |
| fifo_empty | output | 1 | FIFO holds no characters |
| busy | output | 1 | Data pending or frame in flight |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The FIFO flags and `busy` change one cycle after the edge that accepts a write. The start bit appears the cycle after the edge that sees `tx_en` high with a non-empty FIFO. Every later bit changes on the clock after its sixteenth strobe. The bench model updates on each rising edge with exactly these latencies. All four outputs are compared against the model at the following falling edge, so every result is sampled in the cycle it is due. The strobe spacing is varied across scenarios, and each mismatch names the frame field or flag it concerns.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr, wr_ptr;
    logic [CW-1:0]     count;
    logic              push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clear,
    output logic bit_end
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = run && tick && (cnt == LAST);

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !clear) |=> $stable(cnt));

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    input  frame_cfg_t        cfg_in,
    input  logic              bit_end,
    output logic              pop,
    output logic              active,
    output logic              tx_line
);
    localparam int MIN_BITS = DATA_W - 3;
    localparam int IW       = $clog2(DATA_W);

    tx_state_e         state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [IW-1:0]     idx, last_idx;
    logic              stop_seen, par_q, load_ok;
    frame_cfg_t        cfg_q;

    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] sel);
        return {DATA_W{1'b1}} >> (2'd3 - sel);
    endfunction

    assign load_ok  = tx_en && !fifo_empty;
    assign last_idx = IW'(MIN_BITS - 1) + IW'(cfg_q.len_sel);

    always_comb begin
        nxt = state;
        pop = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (load_ok) begin
                    nxt = S_START;
                    pop = 1'b1;
                end
            end
            S_START:  if (bit_end) nxt = S_DATA;
            S_DATA: begin
                if (bit_end && idx == last_idx)
                    nxt = cfg_q.par_en ? S_PARITY : S_STOP;
            end
            S_PARITY: if (bit_end) nxt = S_STOP;
            S_STOP: begin
                if (bit_end && (!cfg_q.two_stop || stop_seen)) begin
                    if (load_ok) begin
                        nxt = S_START;
                        pop = 1'b1;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            stop_seen <= 1'b0;
            par_q     <= 1'b0;
            cfg_q     <= '0;
        end else if (pop) begin
            shreg     <= head;
            cfg_q     <= cfg_in;
            par_q     <= (^(head & len_mask(cfg_in.len_sel))) ^ cfg_in.par_odd;
            idx       <= '0;
            stop_seen <= 1'b0;
        end else begin
            if (state == S_DATA && bit_end) begin
                shreg <= {1'b0, shreg[DATA_W-1:1]};
                idx   <= idx + 1'b1;
            end
            if (state == S_STOP && bit_end) stop_seen <= 1'b1;
        end
    end

    always_comb begin
        active = (state != S_IDLE);
        unique case (state)
            S_START:  tx_line = 1'b0;
            S_DATA:   tx_line = shreg[0];
            S_PARITY: tx_line = par_q;
            default:  tx_line = 1'b1;
        endcase
    end

    assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !tx_en) |=> state == S_IDLE);

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && !pop) |=> $stable(cfg_q));

    assert_data_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> idx <= last_idx);

    assert_one_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP && bit_end && !cfg_q.two_stop) |=> state != S_STOP);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int OSR        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              busy,
    output logic              tx_line
);
    frame_cfg_t        cfg;
    logic [DATA_W-1:0] head;
    logic              pop, active, bit_end;

    assign cfg  = '{len_sel: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_stop2};
    assign busy = active || !fifo_empty;

    sertx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .wdata (wr_data),
        .pop   (pop),
        .rdata (head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    sertx_bitclk #(.OSR(OSR)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (active),
        .clear   (pop),
        .bit_end (bit_end)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .fifo_empty (fifo_empty),
        .head       (head),
        .cfg_in     (cfg),
        .bit_end    (bit_end),
        .pop        (pop),
        .active     (active),
        .tx_line    (tx_line)
    );

    assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(active));

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    localparam int DEPTH = 4;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tx_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       fifo_full, fifo_empty, busy, tx_line;

    int    checks = 0, errors = 0;
    int    tick_div = 1, tk = 0;
    string scen = "R1 reset";

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .busy(busy), .tx_line(tx_line)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tk++;
        tick = ((tk % tick_div) == 0);
    end

    // Behavioural reference: pending characters, bits of the frame in flight.
    logic [7:0] mq[$];
    bit         fb[$];
    int         fk[$];
    int         tcnt = 0, pre = 0;
    bit         act = 0, ld = 0;

    function automatic void build(input logic [7:0] d);
        bit p;
        fb.delete(); fk.delete();
        fb.push_back(1'b0); fk.push_back(2);
        p = cfg_par_odd;
        for (int i = 0; i < 5 + int'(cfg_len); i++) begin
            fb.push_back(d[i]); fk.push_back(3);
            p ^= d[i];
        end
        if (cfg_par_en) begin fb.push_back(p); fk.push_back(5); end
        fb.push_back(1'b1); fk.push_back(4);
        if (cfg_stop2) begin fb.push_back(1'b1); fk.push_back(4); end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); fb.delete(); fk.delete();
            tcnt = 0; act = 0;
        end else begin
            pre = mq.size();
            ld  = 0;
            if (act) begin
                if (tick) begin
                    if (tcnt == 15) begin
                        tcnt = 0;
                        void'(fb.pop_front());
                        void'(fk.pop_front());
                        if (fb.size() == 0) begin
                            act = 0;
                            ld  = tx_en && pre > 0;
                        end
                    end else begin
                        tcnt++;
                    end
                end
            end else begin
                ld = tx_en && pre > 0;
            end
            if (ld) begin
                build(mq.pop_front());
                act  = 1;
                tcnt = 0;
            end
            if (wr_en && pre < DEPTH) mq.push_back(wr_data);
        end
    end

    function automatic string kind_tag(input int k);
        case (k)
            2:       return "R2 start bit";
            3:       return "R3 data bit";
            5:       return "R5 parity bit";
            default: return "R4 stop bit";
        endcase
    endfunction

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] got=%0b exp=%0b at %0t", what, scen, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tx_line, act ? fb[0] : 1'b1, act ? kind_tag(fk[0]) : "R9 idle line");
            chk(busy, act || (mq.size() > 0), "R8 busy");
            chk(fifo_full, mq.size() == DEPTH, "R7 full flag");
            chk(fifo_empty, mq.size() == 0, "R7 empty flag");
        end
    end

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic s2);
        cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    endtask

    task automatic drain();
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (!act && mq.size() == 0) break;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired [%s]", scen);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line, 1'b1, "R1 reset line");
        chk(busy, 1'b0, "R1 reset busy");
        chk(fifo_empty, 1'b1, "R1 reset empty");
        chk(fifo_full, 1'b0, "R1 reset full");

        scen = "R3 R10 eight bits, no parity, tick every cycle";
        tx_en = 1'b1; tick_div = 1; set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        put(8'hA5); drain();

        scen = "R5 R4 five bits even parity two stops, tick every 3rd";
        tick_div = 3; set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
        put(8'h13); put(8'hFF); drain();

        scen = "R5 seven bits odd parity";
        tick_div = 2; set_cfg(2'd2, 1'b1, 1'b1, 1'b0);
        put(8'h6C); put(8'h00); drain();

        scen = "R7 R8 overfill while disabled";
        tx_en = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) put(8'h30 + 8'(i));
        repeat (60) @(negedge clk);
        scen = "R9 back-to-back after enable";
        tx_en = 1'b1; set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        drain();

        scen = "R8 R9 disable during a frame";
        set_cfg(2'd1, 1'b0, 1'b0, 1'b1);
        put(8'h2B); put(8'h14); put(8'h3E);
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        repeat (1500) @(negedge clk);
        tx_en = 1'b1;
        drain();

        scen = "R6 settings change mid-frame";
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        put(8'h5A); put(8'hC3);
        repeat (30) @(negedge clk);
        set_cfg(2'd0, 1'b0, 1'b1, 1'b1);
        drain();

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule